// File: doc/BRIEF.md
# Cache QoS Way Partitioning Monitor

This block sits beside the victim selector of one slice of a shared, set-associative last-level cache. Each lookup arrives with a QoS domain identifier, a flag telling whether it is an instruction or a data access, and the hit result from the tag array. Every domain has two way masks, one for instruction fills and one for data fills. On a miss, the block picks a victim way with a tree pseudo-LRU. The walk is steered away from any subtree that holds no way the domain may fill into. It reports the chosen way, or reports that the fill bypasses the cache when the mask is empty.

Each line remembers which domain allocated it. An occupancy counter per domain rises when that domain fills a line and falls when a line it owns is chosen as a victim. A small configuration port writes the masks and reads back the masks and the counter of one domain. The tag and data arrays and coherence are outside the block. The fill and eviction results are registered and appear in the cycle after the request. Only hits and fills change the pseudo-LRU state.

Top module: `qos_way_partition`

## Requirements
- R1: After reset every instruction mask and data mask reads 16'hFFFF, every occupancy count reads 0, and fill_valid, fill_bypass and evict_valid are 0.
- R2: A miss whose selected mask is non-zero raises fill_valid in the following cycle, with fill_way inside that mask and alloc_mask equal to the mask used.
- R3: The mask is chosen by req_instr: 1 selects the domain's instruction mask and 0 selects its data mask. Each of the two masks is written on its own through cfg_instr.
- R4: A miss whose selected mask is zero raises fill_bypass for one cycle. It raises neither fill_valid nor evict_valid, changes no count and leaves the pseudo-LRU state of the set unchanged.
- R5: A hit allocates nothing, whatever the masks say. It raises neither fill_valid nor fill_bypass and leaves all counts unchanged.
- R6: A fill adds one to the requester's count. When the victim line already held data, evict_valid rises with evict_qos set to the line's stored owner, and that owner's count drops by one.
- R7: Victim choice follows a 15-node tree per set that is all zero at reset. Node 0 is the root and node n has children 2n+1 and 2n+2. A node value of 0 leads toward the lower-numbered ways. An access to way w, whether a hit or a fill, sets every node on the path to point away from w. With a full mask, consecutive misses to a fresh set therefore choose ways 0,8,4,12,2,10,6,14,1,9,5,13,3,11,7,15. When the preferred child has no allowed way, the walk takes the other child.
- R8: A mask write is used by the first request in a later cycle. A request in the same cycle as the write still uses the old mask. Lines already resident outside the new mask stay resident and keep their counts.
- R9: A count never goes past the number of lines in the slice and never goes below zero. A domain that owns every line stays at that number while it keeps filling over its own lines, and every other count stays at 0.
- R10: cfg_imask, cfg_dmask and cfg_count show, in the same cycle, the instruction mask, data mask and count of the domain on cfg_qos.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_set | input | $clog2(NUM_SETS) | Set index of the lookup |
| req_qos | input | $clog2(NUM_QOS) | QoS domain of the requester |
| req_instr | input | 1 | 1 for an instruction access, 0 for data |
| req_hit | input | 1 | Tag array reports a hit |
| req_hit_way | input | $clog2(NUM_WAYS) | Way that hit |
| fill_valid | output | 1 | Previous request allocates a line |
| fill_way | output | $clog2(NUM_WAYS) | Way chosen for the fill |
| fill_bypass | output | 1 | Previous miss does not allocate |
| evict_valid | output | 1 | Fill replaces a resident line |
| evict_qos | output | $clog2(NUM_QOS) | Owner of the replaced line |
| alloc_mask | output | NUM_WAYS | Mask applied to the previous request |
| cfg_we | input | 1 | Write a mask |
| cfg_qos | input | $clog2(NUM_QOS) | Domain addressed for write and readback |
| cfg_instr | input | 1 | 1 writes the instruction mask, 0 the data mask |
| cfg_mask | input | NUM_WAYS | Mask value to write |
| cfg_imask | output | NUM_WAYS | Instruction mask of cfg_qos |
| cfg_dmask | output | NUM_WAYS | Data mask of cfg_qos |
| cfg_count | output | $clog2(NUM_SETS*NUM_WAYS+1) | Occupancy count of cfg_qos |

## Verification
Three kinds of hidden state can go wrong here: a pseudo-LRU tree, an owner recorded against a line, or a counter. A bad tree node shows up as an unexpected fill_way on the very next miss to that set, so fixed fill sequences on fresh sets pin down both the tree order and the masked walk. A wrong stored owner stays hidden until the line is evicted, and then it shows as a wrong evict_qos and a count that moves for the wrong domain. Filling a whole slice from one domain makes any counter slip visible within one readback, because every other count must then read zero.

// File: rtl/qos_part_pkg.sv
// Shared types for the QoS way partitioning block.
package qos_part_pkg;
    // Access class that selects which of a domain's two masks applies.
    typedef enum logic {
        CLS_DATA  = 1'b0,
        CLS_INSTR = 1'b1
    } acc_class_e;
endpackage

// File: rtl/qos_mask_table.sv
// Per-domain allocation masks, one for instruction fills and one for data
// fills. Assumes one write per cycle; lookups read the value held before a
// write in the same cycle, so a new mask applies from the next cycle on.
module qos_mask_table
    import qos_part_pkg::*;
#(
    parameter int NQ = 16,
    parameter int NW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [$clog2(NQ)-1:0] wr_id,
    input  acc_class_e            wr_class,
    input  logic [NW-1:0]         wr_mask,
    input  logic [$clog2(NQ)-1:0] lk_id,
    input  acc_class_e            lk_class,
    output logic [NW-1:0]         lk_mask,
    input  logic [$clog2(NQ)-1:0] rd_id,
    output logic [NW-1:0]         rd_imask,
    output logic [NW-1:0]         rd_dmask
);
    logic [NW-1:0] imask [NQ];
    logic [NW-1:0] dmask [NQ];

    // Reset every mask to all ways allowed, then apply configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NQ; i++) begin
                imask[i] <= '1;
                dmask[i] <= '1;
            end
        end else if (wr_en) begin
            if (wr_class == CLS_INSTR) imask[wr_id] <= wr_mask;
            else                       dmask[wr_id] <= wr_mask;
        end
    end

    // Mask that governs the current lookup.
    always_comb lk_mask = (lk_class == CLS_INSTR) ? imask[lk_id] : dmask[lk_id];

    // Readback for the configuration port.
    always_comb begin
        rd_imask = imask[rd_id];
        rd_dmask = dmask[rd_id];
    end
endmodule

// File: rtl/qos_plru.sv
// Tree pseudo-LRU per set, with a victim walk that avoids subtrees holding no
// allowed way. Assumes NW is a power of two of at least 2. Node n has
// children 2n+1 and 2n+2; a node at 0 prefers the lower half.
module qos_plru #(
    parameter int NS = 32,
    parameter int NW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [$clog2(NS)-1:0] lk_set,
    input  logic [NW-1:0]         lk_mask,
    output logic [$clog2(NW)-1:0] victim,
    input  logic                  upd_en,
    input  logic [$clog2(NS)-1:0] upd_set,
    input  logic [$clog2(NW)-1:0] upd_way
);
    localparam int LVL = $clog2(NW);

    logic [NW-2:0] tree [NS];

    // Walk from the root, taking the preferred child unless it has no allowed way.
    function automatic logic [LVL-1:0] pick(input logic [NW-2:0] t, input logic [NW-1:0] m);
        int node = 0;
        int base = 0;
        for (int l = 0; l < LVL; l++) begin
            int half;
            logic [NW-1:0] lo;
            logic la, ra, go_r;
            half = NW >> (l + 1);
            lo   = (NW'(1) << half) - NW'(1);
            la   = |((m >> base) & lo);
            ra   = |((m >> (base + half)) & lo);
            go_r = t[node] ? ra : ~la;
            if (go_r) base = base + half;
            node = 2 * node + 1 + (go_r ? 1 : 0);
        end
        return LVL'(base);
    endfunction

    // Point every node on the path of way w away from w.
    function automatic logic [NW-2:0] touch(input logic [NW-2:0] t, input logic [LVL-1:0] w);
        logic [NW-2:0] r;
        int node = 0;
        r = t;
        for (int l = 0; l < LVL; l++) begin
            logic b;
            b       = w[LVL-1-l];
            r[node] = ~b;
            node    = 2 * node + 1 + (b ? 1 : 0);
        end
        return r;
    endfunction

    // Victim for the set being looked up.
    always_comb victim = pick(tree[lk_set], lk_mask);

    // Clear all trees on reset; update the accessed set on a hit or a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) tree[s] <= '0;
        end else if (upd_en) begin
            tree[upd_set] <= touch(tree[upd_set], upd_way);
        end
    end

    // R2: a non-empty mask always yields a victim inside it.
    a_r2_victim_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_mask != '0) |-> lk_mask[victim]);
endmodule

// File: rtl/qos_line_owner.sv
// Valid bit and allocating domain for every line of the slice. Assumes NS is
// a power of two so {set, way} forms a dense line index.
module qos_line_owner #(
    parameter int NS = 32,
    parameter int NW = 16,
    parameter int NQ = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [$clog2(NS)-1:0] rd_set,
    input  logic [$clog2(NW)-1:0] rd_way,
    output logic                  rd_valid,
    output logic [$clog2(NQ)-1:0] rd_owner,
    input  logic                  wr_en,
    input  logic [$clog2(NS)-1:0] wr_set,
    input  logic [$clog2(NW)-1:0] wr_way,
    input  logic [$clog2(NQ)-1:0] wr_owner
);
    localparam int LINES = NS * NW;
    localparam int QW    = $clog2(NQ);

    logic          vld   [LINES];
    logic [QW-1:0] owner [LINES];

    // Start with every line empty; record the owner of each filled line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) vld[i] <= 1'b0;
        end else if (wr_en) begin
            vld[{wr_set, wr_way}]   <= 1'b1;
            owner[{wr_set, wr_way}] <= wr_owner;
        end
    end

    // State of the candidate victim line.
    always_comb begin
        rd_valid = vld[{rd_set, rd_way}];
        rd_owner = owner[{rd_set, rd_way}];
    end
endmodule

// File: rtl/qos_occupancy.sv
// Per-domain line counters. Assumes at most one increment and one decrement
// per cycle; when both hit the same domain the count is left alone. Counts
// saturate at LINES and stop at zero.
module qos_occupancy #(
    parameter int NQ    = 16,
    parameter int LINES = 512
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       inc_en,
    input  logic [$clog2(NQ)-1:0]      inc_id,
    input  logic                       dec_en,
    input  logic [$clog2(NQ)-1:0]      dec_id,
    input  logic [$clog2(NQ)-1:0]      rd_id,
    output logic [$clog2(LINES+1)-1:0] rd_count
);
    localparam int QW = $clog2(NQ);
    localparam int CW = $clog2(LINES + 1);

    logic [CW-1:0] cnt [NQ];

    // Clear the counts on reset, then apply the net change for each domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NQ; i++) cnt[i] <= '0;
        end else begin
            for (int i = 0; i < NQ; i++) begin
                if (inc_en && inc_id == QW'(i) && !(dec_en && dec_id == QW'(i))) begin
                    if (cnt[i] < CW'(LINES)) cnt[i] <= cnt[i] + 1'b1;
                end else if (dec_en && dec_id == QW'(i) && !(inc_en && inc_id == QW'(i))) begin
                    if (cnt[i] != '0) cnt[i] <= cnt[i] - 1'b1;
                end
            end
        end
    end

    // Readback for the configuration port.
    always_comb rd_count = cnt[rd_id];

    // R9: the owner store never evicts a line for a domain whose count is zero.
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !(inc_en && inc_id == dec_id)) |-> (cnt[dec_id] != '0));
endmodule

// File: rtl/qos_way_partition.sv
// Top of the QoS way partitioning monitor for one cache slice. Takes one
// lookup per cycle with its hit result, selects the domain's mask, picks a
// masked pseudo-LRU victim on a miss and keeps per-domain occupancy. Results
// are registered and appear the cycle after the lookup.
module qos_way_partition
    import qos_part_pkg::*;
#(
    parameter int NUM_QOS  = 16,
    parameter int NUM_WAYS = 16,
    parameter int NUM_SETS = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid,
    input  logic [$clog2(NUM_SETS)-1:0]            req_set,
    input  logic [$clog2(NUM_QOS)-1:0]             req_qos,
    input  logic                                   req_instr,
    input  logic                                   req_hit,
    input  logic [$clog2(NUM_WAYS)-1:0]            req_hit_way,
    output logic                                   fill_valid,
    output logic [$clog2(NUM_WAYS)-1:0]            fill_way,
    output logic                                   fill_bypass,
    output logic                                   evict_valid,
    output logic [$clog2(NUM_QOS)-1:0]             evict_qos,
    output logic [NUM_WAYS-1:0]                    alloc_mask,
    input  logic                                   cfg_we,
    input  logic [$clog2(NUM_QOS)-1:0]             cfg_qos,
    input  logic                                   cfg_instr,
    input  logic [NUM_WAYS-1:0]                    cfg_mask,
    output logic [NUM_WAYS-1:0]                    cfg_imask,
    output logic [NUM_WAYS-1:0]                    cfg_dmask,
    output logic [$clog2(NUM_SETS*NUM_WAYS+1)-1:0] cfg_count
);
    localparam int LINES = NUM_SETS * NUM_WAYS;
    localparam int WW    = $clog2(NUM_WAYS);
    localparam int QW    = $clog2(NUM_QOS);

    logic [NUM_WAYS-1:0] lk_mask;
    logic [WW-1:0]       victim;
    logic                vict_valid;
    logic [QW-1:0]       vict_owner;
    logic                miss, do_fill, do_bypass, plru_upd;
    logic [WW-1:0]       plru_way;

    qos_mask_table #(.NQ(NUM_QOS), .NW(NUM_WAYS)) u_masks (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_id    (cfg_qos),
        .wr_class (acc_class_e'(cfg_instr)),
        .wr_mask  (cfg_mask),
        .lk_id    (req_qos),
        .lk_class (acc_class_e'(req_instr)),
        .lk_mask  (lk_mask),
        .rd_id    (cfg_qos),
        .rd_imask (cfg_imask),
        .rd_dmask (cfg_dmask)
    );

    // Classify the lookup and decide what the replacement state sees.
    always_comb begin
        miss      = req_valid && !req_hit;
        do_fill   = miss && (lk_mask != '0);
        do_bypass = miss && (lk_mask == '0);
        plru_upd  = (req_valid && req_hit) || do_fill;
        plru_way  = req_hit ? req_hit_way : victim;
    end

    qos_plru #(.NS(NUM_SETS), .NW(NUM_WAYS)) u_plru (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_set  (req_set),
        .lk_mask (lk_mask),
        .victim  (victim),
        .upd_en  (plru_upd),
        .upd_set (req_set),
        .upd_way (plru_way)
    );

    qos_line_owner #(.NS(NUM_SETS), .NW(NUM_WAYS), .NQ(NUM_QOS)) u_owner (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (req_set),
        .rd_way   (victim),
        .rd_valid (vict_valid),
        .rd_owner (vict_owner),
        .wr_en    (do_fill),
        .wr_set   (req_set),
        .wr_way   (victim),
        .wr_owner (req_qos)
    );

    qos_occupancy #(.NQ(NUM_QOS), .LINES(LINES)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_en   (do_fill),
        .inc_id   (req_qos),
        .dec_en   (do_fill && vict_valid),
        .dec_id   (vict_owner),
        .rd_id    (cfg_qos),
        .rd_count (cfg_count)
    );

    // Register the allocation decision for the victim selector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_valid  <= 1'b0;
            fill_way    <= '0;
            fill_bypass <= 1'b0;
            evict_valid <= 1'b0;
            evict_qos   <= '0;
            alloc_mask  <= '0;
        end else begin
            fill_valid  <= do_fill;
            fill_way    <= victim;
            fill_bypass <= do_bypass;
            evict_valid <= do_fill && vict_valid;
            evict_qos   <= vict_owner;
            alloc_mask  <= req_valid ? lk_mask : '0;
        end
    end

    // R2: a reported fill lies inside the mask reported with it.
    a_r2_fill_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> alloc_mask[fill_way]);

    // R2: a miss with allowed ways produces a fill next cycle.
    a_r2_miss_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_hit && lk_mask != '0) |=> fill_valid);

    // R4: an empty mask yields a bypass with no fill and no eviction.
    a_r4_zero_mask_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_hit && lk_mask == '0) |=> (fill_bypass && !fill_valid && !evict_valid));

    // R5: a hit never allocates.
    a_r5_hit_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_hit) |=> (!fill_valid && !fill_bypass));

    // R6: an eviction only accompanies a fill.
    a_r6_evict_with_fill: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> fill_valid);
endmodule

// File: tb/qos_way_partition_test.sv
// Directed bench for the QoS way partitioning monitor.
module qos_way_partition_test;
    localparam int NQ = 16;
    localparam int NW = 16;
    localparam int NS = 16;
    localparam int LINES = NS * NW;
    localparam int CW = $clog2(LINES + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [$clog2(NS)-1:0] req_set = '0;
    logic [$clog2(NQ)-1:0] req_qos = '0;
    logic req_instr = 1'b0;
    logic req_hit = 1'b0;
    logic [$clog2(NW)-1:0] req_hit_way = '0;
    logic fill_valid, fill_bypass, evict_valid;
    logic [$clog2(NW)-1:0] fill_way;
    logic [$clog2(NQ)-1:0] evict_qos;
    logic [NW-1:0] alloc_mask;
    logic cfg_we = 1'b0;
    logic [$clog2(NQ)-1:0] cfg_qos = '0;
    logic cfg_instr = 1'b0;
    logic [NW-1:0] cfg_mask = '0;
    logic [NW-1:0] cfg_imask, cfg_dmask;
    logic [CW-1:0] cfg_count;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    qos_way_partition #(.NUM_QOS(NQ), .NUM_WAYS(NW), .NUM_SETS(NS)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_set(req_set), .req_qos(req_qos),
        .req_instr(req_instr), .req_hit(req_hit), .req_hit_way(req_hit_way),
        .fill_valid(fill_valid), .fill_way(fill_way), .fill_bypass(fill_bypass),
        .evict_valid(evict_valid), .evict_qos(evict_qos), .alloc_mask(alloc_mask),
        .cfg_we(cfg_we), .cfg_qos(cfg_qos), .cfg_instr(cfg_instr), .cfg_mask(cfg_mask),
        .cfg_imask(cfg_imask), .cfg_dmask(cfg_dmask), .cfg_count(cfg_count)
    );

    task automatic chk(input string tag, input longint got, input longint exp);
        nchk++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    // One lookup; returns at the falling edge after its result is registered.
    task automatic send(input int s, input int q, input bit instr, input bit hit, input int hw);
        @(negedge clk);
        req_valid = 1'b1; req_set = s[$clog2(NS)-1:0]; req_qos = q[$clog2(NQ)-1:0];
        req_instr = instr; req_hit = hit; req_hit_way = hw[$clog2(NW)-1:0];
        @(negedge clk);
        req_valid = 1'b0; req_hit = 1'b0;
    endtask

    task automatic wr_mask(input int q, input bit instr, input logic [NW-1:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_qos = q[$clog2(NQ)-1:0]; cfg_instr = instr; cfg_mask = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic count_of(input int q, output int c);
        cfg_qos = q[$clog2(NQ)-1:0];
        #0.5;
        c = int'(cfg_count);
    endtask

    task automatic t_reset;
        int c;
        chk("R1 fill_valid", fill_valid, 0);
        chk("R1 fill_bypass", fill_bypass, 0);
        chk("R1 evict_valid", evict_valid, 0);
        for (int q = 0; q < NQ; q += 5) begin
            count_of(q, c);
            chk("R1 count", c, 0);
            chk("R1 imask", cfg_imask, 16'hFFFF);
            chk("R1 dmask", cfg_dmask, 16'hFFFF);
        end
    endtask

    task automatic t_plru_order;
        int exp_w [16] = '{0,8,4,12,2,10,6,14,1,9,5,13,3,11,7,15};
        int c;
        for (int i = 0; i < 16; i++) begin
            send(0, 1, 1'b0, 1'b0, 0);
            chk("R7 order way", fill_way, exp_w[i]);
            chk("R2 fill_valid", fill_valid, 1);
            chk("R6 no evict on empty line", evict_valid, 0);
        end
        chk("R2 alloc_mask", alloc_mask, 16'hFFFF);
        count_of(1, c);
        chk("R6 count after fills", c, 16);
        send(0, 2, 1'b0, 1'b0, 0);
        chk("R7 wraps to way 0", fill_way, 0);
        chk("R6 evict_valid", evict_valid, 1);
        chk("R6 evict_qos", evict_qos, 1);
        count_of(1, c);
        chk("R6 owner decremented", c, 15);
        count_of(2, c);
        chk("R6 requester incremented", c, 1);
    endtask

    task automatic t_masked_walk;
        int exp_w [4] = '{4,6,5,7};
        int c;
        wr_mask(4, 1'b0, 16'h00F0);
        for (int i = 0; i < 4; i++) begin
            send(1, 4, 1'b0, 1'b0, 0);
            chk("R7 masked walk way", fill_way, exp_w[i]);
            chk("R2 alloc_mask used", alloc_mask, 16'h00F0);
        end
        count_of(4, c);
        chk("R6 count masked fills", c, 4);
        send(2, 4, 1'b1, 1'b0, 0);
        chk("R3 instr mask untouched by data write", fill_way, 0);
        chk("R3 instr alloc_mask", alloc_mask, 16'hFFFF);
    endtask

    task automatic t_class_split;
        wr_mask(5, 1'b1, 16'h8000);
        send(3, 5, 1'b1, 1'b0, 0);
        chk("R3 instr fill uses instr mask", fill_way, 15);
        send(3, 5, 1'b0, 1'b0, 0);
        chk("R3 data fill uses data mask", fill_way, 0);
        chk("R3 data alloc_mask", alloc_mask, 16'hFFFF);
    endtask

    task automatic t_write_timing;
        int c;
        @(negedge clk);
        cfg_we = 1'b1; cfg_qos = 4'd6; cfg_instr = 1'b0; cfg_mask = 16'h0F00;
        req_valid = 1'b1; req_set = 4'd4; req_qos = 4'd6; req_instr = 1'b0; req_hit = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        chk("R8 same-cycle write uses old mask", fill_way, 0);
        send(4, 6, 1'b0, 1'b0, 0);
        chk("R8 next request uses new mask", fill_way, 8);
        send(4, 6, 1'b0, 1'b1, 0);
        chk("R5 hit outside mask no fill", fill_valid, 0);
        chk("R5 hit no bypass", fill_bypass, 0);
        count_of(6, c);
        chk("R8 resident line keeps count", c, 2);
    endtask

    task automatic t_zero_mask;
        int c;
        wr_mask(7, 1'b0, 16'h0000);
        send(6, 7, 1'b0, 1'b0, 0);
        chk("R4 bypass", fill_bypass, 1);
        chk("R4 no fill", fill_valid, 0);
        chk("R4 no evict", evict_valid, 0);
        count_of(7, c);
        chk("R4 count unchanged", c, 0);
        send(6, 8, 1'b0, 1'b0, 0);
        chk("R4 tree untouched", fill_way, 0);
        chk("R4 bypass cleared", fill_bypass, 0);
    endtask

    task automatic t_hit_touch;
        int c;
        send(7, 9, 1'b0, 1'b1, 0);
        chk("R5 hit no fill", fill_valid, 0);
        send(7, 9, 1'b0, 1'b0, 0);
        chk("R7 hit moves tree", fill_way, 8);
        count_of(9, c);
        chk("R5 only the fill counted", c, 1);
    endtask

    task automatic t_saturate;
        int c;
        for (int s = 0; s < NS; s++)
            for (int i = 0; i < NW; i++) send(s, 10, 1'b0, 1'b0, 0);
        count_of(10, c);
        chk("R9 owns every line", c, LINES);
        for (int i = 0; i < NW; i++) send(0, 10, 1'b0, 1'b0, 0);
        chk("R6 self eviction owner", evict_qos, 10);
        chk("R6 self eviction valid", evict_valid, 1);
        count_of(10, c);
        chk("R9 stays at line count", c, LINES);
        for (int q = 0; q < NQ; q++) begin
            if (q != 10) begin
                count_of(q, c);
                chk("R9 others at zero", c, 0);
            end
        end
    endtask

    task automatic t_readback;
        wr_mask(12, 1'b1, 16'hA5A5);
        wr_mask(12, 1'b0, 16'h5A5A);
        cfg_qos = 4'd12; #0.5;
        chk("R10 imask readback", cfg_imask, 16'hA5A5);
        chk("R10 dmask readback", cfg_dmask, 16'h5A5A);
        cfg_qos = 4'd13; #0.5;
        chk("R10 neighbour imask", cfg_imask, 16'hFFFF);
        chk("R10 neighbour dmask", cfg_dmask, 16'hFFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_plru_order;
        t_masked_walk;
        t_class_split;
        t_write_timing;
        t_zero_mask;
        t_hit_touch;
        t_readback;
        t_saturate;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule